// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Bit-Masked Register Writes

This block serves one port of eight general-purpose pins and sits on a simple 32-bit register bus. Each pin has three writable control bits. A mode bit chooses between software control and the pin's special-function logic. A drive-enable bit turns the pad driver on. A level bit gives the value that is driven. A read-only word shows the pad levels after they have been synchronised to the bus clock.

Each writable word can be reached at two addresses. A plain write replaces all eight bits. The alias address sits a fixed offset above the plain address. A write there carries a per-pin enable byte next to the value byte, so software can change selected pins in a single bus cycle, with no read-modify-write. When a pin is not in software mode, the special-function drive and enable pass straight through to the pad.

The port answers only addresses whose port field matches its own index. This lets several instances share one decoded window.

Top module: `gpio_port`

## Requirements
- R1: After reset, the mode, drive-enable and level words all read 0, at both their plain and alias addresses.
- R2: A plain write replaces all eight bits of the addressed word with `bus_wdata[7:0]`. Bits [31:8] are ignored. The new value is visible on the read port in the cycle after the write edge.
- R3: A write to an alias address treats `bus_wdata[15:8]` as per-pin enables and `bus_wdata[7:0]` as new values. A pin whose enable is 0 keeps its old bit.
- R4: A read from an alias address returns the current plain word in bits [7:0] and zeros in bits [31:8].
- R5: For a pin with mode bit 1, `pad_oe` equals its drive-enable bit and `pad_out` equals its level bit.
- R6: For a pin with mode bit 0, `pad_oe` equals `sf_oe` and `pad_out` equals `sf_out` for that pin.
- R7: The input word equals `pad_in` as it was two clock edges earlier. After a pad change, a read shows the old value after one edge and the new value after two edges.
- R8: The following writes change no state: a write to the input word, at its plain or alias address, and a write whose port field `bus_addr[3:2]` differs from `PORT_IDX`.
- R9: Word layout, as byte addresses with port field p = `bus_addr[3:2]`: mode at 0x00+4p, drive-enable at 0x10+4p, level at 0x20+4p, input at 0x30+4p. Each alias is 0x80 higher. A read of any other address, or of another port, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS (8) | Raw pad levels, asynchronous |
| pad_out | output | NPINS (8) | Value driven to each pad |
| pad_oe | output | NPINS (8) | Pad driver enable |
| sf_out | input | NPINS (8) | Special-function drive value |
| sf_oe | input | NPINS (8) | Special-function driver enable |

## Verification
The masked-write path is exercised with three patterns:
- Enable only the low nibble, so disabled pins are shown to keep their bits.
- Enable only the high nibble with all value bits set, so enabled pins are shown to take the new value.
- An all-zero enable byte with nonzero values, which must change nothing.

The pad mux is checked with a split mode word, half software and half special function, using drive and special-function patterns that differ in every bit. Any pin that takes the wrong source therefore shows up.

Input sampling is read after one edge and again after two edges, which pins the synchroniser depth exactly. Writes to the input word and to a neighbouring port confirm that neither one disturbs state.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DRIVE,
        SEL_LEVEL,
        SEL_INPUT
    } reg_sel_e;
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PORT_IDX  = 0,
    parameter int ALIAS_OFS = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              alias_hit
);
    localparam logic [ADDR_W-1:0] ALIAS_MASK = ADDR_W'(ALIAS_OFS);
    localparam logic [1:0]        PORT_FIELD = 2'(PORT_IDX);

    logic [ADDR_W-1:0] plain_ofs;
    logic              in_port;

    assign plain_ofs = addr & ~ALIAS_MASK;
    assign alias_hit = |(addr & ALIAS_MASK);
    assign in_port   = (plain_ofs[ADDR_W-1:6] == '0) &&
                       (plain_ofs[3:2] == PORT_FIELD) &&
                       (plain_ofs[1:0] == 2'b00);

    always_comb begin
        sel = SEL_NONE;
        if (in_port) begin
            unique case (plain_ofs[5:4])
                2'd0: sel = SEL_MODE;
                2'd1: sel = SEL_DRIVE;
                2'd2: sel = SEL_LEVEL;
                2'd3: sel = SEL_INPUT;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg #(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               masked,
    input  logic [2*NPINS-1:0] wdata,
    output logic [NPINS-1:0]   q
);
    logic [NPINS-1:0] q_next;

    for (genvar b = 0; b < NPINS; b++) begin : g_bit
        logic take;
        assign take      = wr_en && (!masked || wdata[NPINS+b]);
        assign q_next[b] = take ? wdata[b] : q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    logic [NPINS-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS     = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int PORT_IDX  = 0,
    parameter int ALIAS_OFS = 'h80,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  sf_out,
    input  logic [NPINS-1:0]  sf_oe
);
    localparam int WPAIR_W = 2 * NPINS;

    reg_sel_e         sel;
    logic             alias_hit;
    logic [NPINS-1:0] mode_q, drive_q, level_q, in_q;
    logic [NPINS-1:0] rd_word;

    gpio_port_decode #(
        .ADDR_W(ADDR_W), .PORT_IDX(PORT_IDX), .ALIAS_OFS(ALIAS_OFS)
    ) i_decode (
        .addr(bus_addr), .sel(sel), .alias_hit(alias_hit)
    );

    gpio_port_reg #(.NPINS(NPINS)) i_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && sel == SEL_MODE),
        .masked(alias_hit), .wdata(bus_wdata[WPAIR_W-1:0]), .q(mode_q)
    );

    gpio_port_reg #(.NPINS(NPINS)) i_drive (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && sel == SEL_DRIVE),
        .masked(alias_hit), .wdata(bus_wdata[WPAIR_W-1:0]), .q(drive_q)
    );

    gpio_port_reg #(.NPINS(NPINS)) i_level (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && sel == SEL_LEVEL),
        .masked(alias_hit), .wdata(bus_wdata[WPAIR_W-1:0]), .q(level_q)
    );

    gpio_port_sync #(.NPINS(NPINS), .STAGES(SYNC_LEN)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
    );

    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_MODE:  rd_word = mode_q;
            SEL_DRIVE: rd_word = drive_q;
            SEL_LEVEL: rd_word = level_q;
            SEL_INPUT: rd_word = in_q;
            default:   rd_word = '0;
        endcase
    end

    assign bus_rdata = {{(DATA_W-NPINS){1'b0}}, rd_word};

    for (genvar p = 0; p < NPINS; p++) begin : g_pad
        assign pad_out[p] = mode_q[p] ? level_q[p] : sf_out[p];
        assign pad_oe[p]  = mode_q[p] ? drive_q[p] : sf_oe[p];
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPINS     = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int PORT_IDX  = 0,
    parameter int ALIAS_OFS = 'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  sf_out,
    input logic [NPINS-1:0]  sf_oe,
    input logic [NPINS-1:0]  mode_q,
    input logic [NPINS-1:0]  drive_q,
    input logic [NPINS-1:0]  level_q,
    input logic [NPINS-1:0]  in_q
);
    localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(PORT_IDX * 4);
    localparam logic [ADDR_W-1:0] A_LEVEL_M = ADDR_W'('h20 + PORT_IDX * 4 + ALIAS_OFS);
    localparam logic [1:0]        PORT_F    = 2'(PORT_IDX);

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        warm <= '0;
        else if (warm < 2) warm <= warm + 2'd1;
    end

    AST_PLAIN_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == A_MODE) |=> (mode_q == $past(bus_wdata[NPINS-1:0]))); // R2

    AST_MASKED_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == A_LEVEL_M) |=>
        (level_q == (($past(level_q) & ~$past(bus_wdata[2*NPINS-1:NPINS])) |
                     ($past(bus_wdata[NPINS-1:0]) & $past(bus_wdata[2*NPINS-1:NPINS]))))); // R3

    AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (&mode_q) |-> (pad_oe == drive_q && pad_out == level_q)); // R5

    AST_SF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == '0) |-> (pad_oe == sf_oe && pad_out == sf_out)); // R6

    AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (in_q == $past(pad_in, 2))); // R7

    AST_FOREIGN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr[3:2] != PORT_F) |=>
        ($stable(mode_q) && $stable(drive_q) && $stable(level_q))); // R8
endmodule

bind gpio_port gpio_port_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_IDX(PORT_IDX), .ALIAS_OFS(ALIAS_OFS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .sf_out(sf_out), .sf_oe(sf_oe), .mode_q(mode_q), .drive_q(drive_q),
    .level_q(level_q), .in_q(in_q)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    localparam logic [11:0] A_MODE  = 12'h000;
    localparam logic [11:0] A_DRIVE = 12'h010;
    localparam logic [11:0] A_LEVEL = 12'h020;
    localparam logic [11:0] A_IN    = 12'h030;
    localparam logic [11:0] ALIAS   = 12'h080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe;
    logic [7:0]  sf_out = '0;
    logic [7:0]  sf_oe = '0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .sf_out(sf_out), .sf_oe(sf_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(A_MODE, d);          check("R1 mode", d, 0);
        reg_read(A_DRIVE, d);         check("R1 drive", d, 0);
        reg_read(A_LEVEL, d);         check("R1 level", d, 0);
        reg_read(A_MODE | ALIAS, d);  check("R1 mode alias", d, 0);
        #1 check("R1 R6 pad_oe idle", {24'b0, pad_oe}, 0);
    endtask

    task automatic t_plain;
        logic [31:0] d;
        reg_write(A_MODE, 32'hFFFF_FF5A);
        reg_read(A_MODE, d);  check("R2 mode plain", d, 32'h5A);
        reg_write(A_LEVEL, 32'h0000_00A5);
        reg_read(A_LEVEL, d); check("R2 level plain", d, 32'hA5);
        reg_write(A_LEVEL, 32'h0000_0003);
        reg_read(A_LEVEL, d); check("R2 full replace", d, 32'h03);
    endtask

    task automatic t_masked;
        logic [31:0] d;
        reg_write(A_MODE, 32'h5A);
        reg_write(A_MODE | ALIAS, 32'h0000_0FF0);
        reg_read(A_MODE, d); check("R3 low nibble enabled", d, 32'h50);
        reg_write(A_MODE | ALIAS, 32'h0000_F0FF);
        reg_read(A_MODE, d); check("R3 high nibble enabled", d, 32'hF0);
        reg_write(A_MODE | ALIAS, 32'h0000_00FF);
        reg_read(A_MODE, d); check("R3 no enables", d, 32'hF0);
        reg_write(A_DRIVE | ALIAS, 32'h0000_8181);
        reg_read(A_DRIVE, d); check("R3 drive masked", d, 32'h81);
        reg_read(A_MODE | ALIAS, d); check("R4 alias read", d, 32'hF0);
    endtask

    task automatic t_pads;
        reg_write(A_MODE, 32'h0F);
        reg_write(A_DRIVE, 32'h33);
        reg_write(A_LEVEL, 32'h55);
        @(negedge clk);
        sf_out = 8'hAA; sf_oe = 8'hCC;
        #1;
        check("R5 R6 pad_oe mix", {24'b0, pad_oe}, 32'hC3);
        check("R5 R6 pad_out mix", {24'b0, pad_out}, 32'hA5);
        reg_write(A_MODE, 32'hFF);
        #1 check("R5 pad_out all gpio", {24'b0, pad_out}, 32'h55);
        reg_write(A_MODE, 32'h00);
        #1 check("R6 pad_oe all sf", {24'b0, pad_oe}, 32'hCC);
    endtask

    task automatic t_input;
        logic [31:0] d;
        @(negedge clk);
        pad_in = 8'h3C;
        reg_read(A_IN, d); check("R7 one edge", d, 32'h00);
        reg_read(A_IN, d); check("R7 two edges", d, 32'h3C);
        reg_read(A_IN | ALIAS, d); check("R4 input alias", d, 32'h3C);
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        reg_write(A_IN, 32'hFF);
        reg_write(A_IN | ALIAS, 32'hFFFF);
        reg_read(A_IN, d); check("R8 input write ignored", d, 32'h3C);
        reg_write(A_MODE, 32'h12);
        reg_write(12'h004, 32'hFF);
        reg_write(12'h084, 32'hFFFF);
        reg_read(A_MODE, d); check("R8 foreign port", d, 32'h12);
        reg_read(12'h004, d); check("R9 foreign read", d, 0);
        reg_read(12'h040, d); check("R9 unmapped read", d, 0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_plain;
        t_masked;
        t_pads;
        t_input;
        t_ignored;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule